// File: doc/BRIEF.md
# Dual-Accumulator Fixed-Point Multiply-Accumulate Unit

This block multiplies two 16-bit operands and merges the product into one of two 40-bit accumulators, called MR and SR, that can be picked on each operation. Each operand is read as signed or unsigned on its own, as a 2-bit format code directs. A mode input picks integer alignment, where the product is not shifted, or fractional alignment, where the product moves one place left so that the accumulator holds a 9.31 value. Each accumulator has its own overflow flag.

An operation is issued by pulsing `valid_i`, and its result shows on the outputs one clock later. A false `cond_i` turns the operation into a no-op. A status-only operation runs the arithmetic against MR and updates only the MR flag, so that code can test a result without overwriting either accumulator. Rounding, saturation, operand selection and decoding are handled outside this block.

Top module: `mac_dual_acc`

## Requirements
- R1: `fmt_i` sets operand signedness in x/y order. Bit 1 set means x is unsigned and bit 0 set means y is unsigned, so 0=both signed, 1=x signed/y unsigned, 2=x unsigned/y signed, 3=both unsigned. The exact product of the extended operands is used.
- R2: With `frac_i`=0 the product is sign-extended to 40 bits and is not shifted.
- R3: With `frac_i`=1 the sign-extended product is shifted left by one bit before it is used.
- R4: After a write, the destination's flag (`mv_o` for MR, `sv_o` for SR) is 1 exactly when bits 39:31 of the new value are not all equal.
- R5: `op_i` 0=load product, 1=accumulator plus product, 2=accumulator minus product. Add and subtract read the same accumulator they write.
- R6: `op_i` 3 (clear) writes zero to the selected accumulator and clears its flag.
- R7: An operation with `cond_i`=0 changes neither accumulator and neither flag.
- R8: With `status_only_i`=1 the operation is computed against MR and only `mv_o` is updated. `mr_o`, `sr_o` and `sv_o` are unchanged.
- R9: `dest_i` 0 selects MR and 1 selects SR. The other accumulator and its flag are not changed.
- R10: Reset clears both accumulators and both flags. A result appears on the outputs on the clock edge that samples `valid_i`=1, and nothing changes while `valid_i`=0.
- R11: Add and subtract wrap modulo 2^40.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operation strobe |
| cond_i | input | 1 | Execute condition; 0 makes the operation a no-op |
| op_i | input | 2 | 0 load, 1 add, 2 subtract, 3 clear |
| dest_i | input | 1 | 0 MR, 1 SR |
| status_only_i | input | 1 | Update the MR flag only |
| fmt_i | input | 2 | Operand signedness code |
| frac_i | input | 1 | 1 fractional alignment, 0 integer |
| x_i | input | 16 | X operand |
| y_i | input | 16 | Y operand |
| mr_o | output | 40 | MR accumulator |
| sr_o | output | 40 | SR accumulator |
| mv_o | output | 1 | MR overflow flag |
| sv_o | output | 1 | SR overflow flag |

## Verification
The properties assume that every control input holds a known value whenever `valid_i` is high, and that the strobe is sampled only on rising edges after reset has been released. The bench drives all inputs on the falling edge and returns `valid_i` low after each sampled edge, so each operation is seen exactly once. Scripted cases cover each format code on the operand extremes, fractional overflow, clear, a false condition and status-only. A long randomized run mixes every opcode, destination and mode, and a bench-side model tracks the expected accumulator and flag values.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2,
    OP_CLR  = 2'd3
  } mac_op_e;

  typedef enum logic {
    DST_MR = 1'b0,
    DST_SR = 1'b1
  } mac_dst_e;

  localparam int unsigned NUM_ACC = 2;
endpackage

// File: rtl/mac_operand_ext.sv
module mac_operand_ext #(
  parameter int unsigned DATA_W = 16
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic              unsigned_i,
  output logic [DATA_W:0]   ext_o
);
  logic fill;
  assign fill  = unsigned_i ? 1'b0 : data_i[DATA_W-1];
  assign ext_o = {fill, data_i};
endmodule

// File: rtl/mac_product_align.sv
module mac_product_align #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ACC_W  = 40
) (
  input  logic [DATA_W:0]  x_ext_i,
  input  logic [DATA_W:0]  y_ext_i,
  input  logic             frac_i,
  output logic [ACC_W-1:0] aligned_o
);
  localparam int unsigned EXT_W  = DATA_W + 1;
  localparam int unsigned PROD_W = 2 * EXT_W;

  logic signed [PROD_W-1:0] prod;
  logic [ACC_W-1:0]         prod_ext;

  assign prod = $signed(x_ext_i) * $signed(y_ext_i);

  generate
    if (ACC_W > PROD_W) begin : g_widen
      assign prod_ext = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
    end else begin : g_trunc
      assign prod_ext = prod[ACC_W-1:0];
    end
  endgenerate

  assign aligned_o = frac_i ? {prod_ext[ACC_W-2:0], 1'b0} : prod_ext;
endmodule

// File: rtl/mac_acc_slot.sv
module mac_acc_slot #(
  parameter int unsigned ACC_W = 40
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_we_i,
  input  logic             flag_we_i,
  input  logic [ACC_W-1:0] acc_d_i,
  input  logic             flag_d_i,
  output logic [ACC_W-1:0] acc_q_o,
  output logic             flag_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q_o  <= '0;
      flag_q_o <= 1'b0;
    end else begin
      if (acc_we_i)  acc_q_o  <= acc_d_i;
      if (flag_we_i) flag_q_o <= flag_d_i;
    end
  end
endmodule

// File: rtl/mac_dual_acc.sv
module mac_dual_acc #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ACC_W  = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic              cond_i,
  input  logic [1:0]        op_i,
  input  logic              dest_i,
  input  logic              status_only_i,
  input  logic [1:0]        fmt_i,
  input  logic              frac_i,
  input  logic [DATA_W-1:0] x_i,
  input  logic [DATA_W-1:0] y_i,
  output logic [ACC_W-1:0]  mr_o,
  output logic [ACC_W-1:0]  sr_o,
  output logic              mv_o,
  output logic              sv_o
);
  import mac_pkg::*;

  localparam int unsigned OVF_LO = 2 * DATA_W - 1;

  logic [DATA_W:0]  x_ext, y_ext;
  logic [ACC_W-1:0] aligned, base, result;
  logic             fire, ovf;
  logic [ACC_W-1:0] acc_q  [NUM_ACC];
  logic             flag_q [NUM_ACC];

  mac_operand_ext #(.DATA_W(DATA_W)) i_ext_x (
    .data_i(x_i), .unsigned_i(fmt_i[1]), .ext_o(x_ext)
  );
  mac_operand_ext #(.DATA_W(DATA_W)) i_ext_y (
    .data_i(y_i), .unsigned_i(fmt_i[0]), .ext_o(y_ext)
  );

  mac_product_align #(.DATA_W(DATA_W), .ACC_W(ACC_W)) i_align (
    .x_ext_i(x_ext), .y_ext_i(y_ext), .frac_i(frac_i), .aligned_o(aligned)
  );

  assign fire = valid_i & cond_i;
  // status-only runs against MR
  assign base = (dest_i == DST_SR && !status_only_i) ? acc_q[1] : acc_q[0];

  always_comb begin
    unique case (mac_op_e'(op_i))
      OP_LOAD: result = aligned;
      OP_ADD:  result = base + aligned;
      OP_SUB:  result = base - aligned;
      default: result = '0;
    endcase
  end

  assign ovf = !((&result[ACC_W-1:OVF_LO]) | ~(|result[ACC_W-1:OVF_LO]));

  generate
    for (genvar k = 0; k < NUM_ACC; k++) begin : g_slot
      logic acc_we, flag_we;
      assign acc_we  = fire & !status_only_i & (dest_i == 1'(k));
      assign flag_we = acc_we | ((k == 0) & fire & status_only_i);
      mac_acc_slot #(.ACC_W(ACC_W)) i_slot (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .acc_we_i(acc_we), .flag_we_i(flag_we),
        .acc_d_i(result), .flag_d_i(ovf),
        .acc_q_o(acc_q[k]), .flag_q_o(flag_q[k])
      );
    end
  endgenerate

  assign mr_o = acc_q[0];
  assign sr_o = acc_q[1];
  assign mv_o = flag_q[0];
  assign sv_o = flag_q[1];
endmodule

// File: rtl/mac_dual_acc_chk.sv
module mac_dual_acc_chk #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned ACC_W  = 40
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic             cond_i,
  input logic [1:0]       op_i,
  input logic             dest_i,
  input logic             status_only_i,
  input logic [ACC_W-1:0] mr_o,
  input logic [ACC_W-1:0] sr_o,
  input logic             mv_o,
  input logic             sv_o
);
  localparam int unsigned LO = 2 * DATA_W - 1;

  logic wr_mr, wr_sr;
  assign wr_mr = valid_i & cond_i & !status_only_i & !dest_i;
  assign wr_sr = valid_i & cond_i & !status_only_i &  dest_i;

  p_cond_false_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !cond_i) |=> ($stable(mr_o) && $stable(sr_o) && $stable(mv_o) && $stable(sv_o)));

  p_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(mr_o) && $stable(sr_o) && $stable(mv_o) && $stable(sv_o)));

  p_status_only_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && cond_i && status_only_i) |=> ($stable(mr_o) && $stable(sr_o) && $stable(sv_o)));

  p_clear_mr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_mr && op_i == 2'd3) |=> (mr_o == '0 && !mv_o));

  p_clear_sr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_sr && op_i == 2'd3) |=> (sr_o == '0 && !sv_o));

  p_mv_rule_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_mr |=> (mv_o == !((&mr_o[ACC_W-1:LO]) || !(|mr_o[ACC_W-1:LO]))));

  p_sv_rule_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_sr |=> (sv_o == !((&sr_o[ACC_W-1:LO]) || !(|sr_o[ACC_W-1:LO]))));

  p_mr_keeps_sr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_mr |=> ($stable(sr_o) && $stable(sv_o)));

  p_sr_keeps_mr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_sr |=> ($stable(mr_o) && $stable(mv_o)));
endmodule

bind mac_dual_acc mac_dual_acc_chk #(.DATA_W(DATA_W), .ACC_W(ACC_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .cond_i(cond_i),
  .op_i(op_i), .dest_i(dest_i), .status_only_i(status_only_i),
  .mr_o(mr_o), .sr_o(sr_o), .mv_o(mv_o), .sv_o(sv_o)
);

// File: tb/test_mac_dual_acc.sv
module test_mac_dual_acc;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0, cond_i = 1'b0, dest_i = 1'b0, status_only_i = 1'b0, frac_i = 1'b0;
  logic [1:0]  op_i = '0, fmt_i = '0;
  logic [15:0] x_i = '0, y_i = '0;
  logic [39:0] mr_o, sr_o;
  logic        mv_o, sv_o;

  always #2 clk_i = ~clk_i;

  mac_dual_acc i_mac_dual_acc (.*);

  typedef struct {
    logic [39:0] mr, sr;
    logic        mv, sv;
    string       tag;
  } exp_t;

  exp_t        q[$];
  int          n_chk = 0, n_bad = 0;
  logic [39:0] m_mr = '0, m_sr = '0;
  logic        m_mv = 0, m_sv = 0;
  bit          done = 0;

  function automatic logic [39:0] prod40(logic [15:0] x, logic [15:0] y, logic [1:0] f, logic fr);
    longint a, b, p;
    a = f[1] ? longint'(x) : longint'($signed(x));
    b = f[0] ? longint'(y) : longint'($signed(y));
    p = a * b;
    if (fr) p = p * 2;
    return p[39:0];
  endfunction

  function automatic logic ovf(logic [39:0] v);
    return !(v[39:31] == 9'h1ff || v[39:31] == 9'h000);
  endfunction

  task automatic cmp(string what, string tag, logic [39:0] act, logic [39:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic do_op(logic v, logic c, logic [1:0] op, logic d, logic st,
                       logic [1:0] f, logic fr, logic [15:0] x, logic [15:0] y, string tag);
    logic [39:0] p, base, res;
    exp_t e;
    @(negedge clk_i);
    valid_i = v; cond_i = c; op_i = op; dest_i = d; status_only_i = st;
    fmt_i = f; frac_i = fr; x_i = x; y_i = y;
    p = prod40(x, y, f, fr);
    base = (d && !st) ? m_sr : m_mr;
    case (op)
      2'd0: res = p;
      2'd1: res = base + p;
      2'd2: res = base - p;
      default: res = '0;
    endcase
    if (v && c) begin
      if (st) m_mv = ovf(res);
      else if (!d) begin m_mr = res; m_mv = ovf(res); end
      else begin m_sr = res; m_sv = ovf(res); end
    end
    @(posedge clk_i);
    #1;
    e.mr = m_mr; e.sr = m_sr; e.mv = m_mv; e.sv = m_sv; e.tag = tag;
    q.push_back(e);
    valid_i = 1'b0;
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk_i);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        cmp("mr", e.tag, mr_o, e.mr);
        cmp("sr", e.tag, sr_o, e.sr);
        cmp("mv", e.tag, 40'(mv_o), 40'(e.mv));
        cmp("sv", e.tag, 40'(sv_o), 40'(e.sv));
      end
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R10 reset state
    cmp("mr", "R10", mr_o, '0);
    cmp("sr", "R10", sr_o, '0);
    cmp("mv", "R10", 40'(mv_o), 40'd0);
    cmp("sv", "R10", 40'(sv_o), 40'd0);

    // R1 R2 format codes on extremes, integer mode
    do_op(1, 1, 2'd0, 0, 0, 2'd0, 0, 16'hfffd, 16'h0007, "R2");
    do_op(1, 1, 2'd0, 0, 0, 2'd0, 0, 16'hffff, 16'hffff, "R1");
    do_op(1, 1, 2'd0, 0, 0, 2'd1, 0, 16'hffff, 16'hffff, "R1");
    do_op(1, 1, 2'd0, 1, 0, 2'd2, 0, 16'hffff, 16'hffff, "R1");
    do_op(1, 1, 2'd0, 1, 0, 2'd3, 0, 16'hffff, 16'hffff, "R1");   // R4: 0x00fffe0001 flags
    // R3 fractional
    do_op(1, 1, 2'd0, 0, 0, 2'd0, 1, 16'h4000, 16'h4000, "R3");
    do_op(1, 1, 2'd0, 0, 0, 2'd0, 1, 16'h8000, 16'h8000, "R4");   // 0x0080000000 -> mv
    // R5 add / subtract on same accumulator
    do_op(1, 1, 2'd1, 1, 0, 2'd0, 0, 16'h1234, 16'h0100, "R5");
    do_op(1, 1, 2'd2, 1, 0, 2'd0, 0, 16'h0002, 16'h0003, "R5");
    // R11 wrap below zero
    do_op(1, 1, 2'd6 - 2'd4, 0, 0, 2'd3, 0, 16'hffff, 16'hffff, "R11");
    do_op(1, 1, 2'd0, 0, 0, 2'd0, 0, 16'h0000, 16'h0000, "R11");
    do_op(1, 1, 2'd2, 0, 0, 2'd0, 0, 16'h0001, 16'h0001, "R11");
    // R6 clear
    do_op(1, 1, 2'd0, 1, 0, 2'd3, 0, 16'hffff, 16'hffff, "R6");
    do_op(1, 1, 2'd3, 1, 0, 2'd0, 0, 16'h1111, 16'h2222, "R6");
    // R7 condition false
    do_op(1, 0, 2'd0, 0, 0, 2'd3, 1, 16'hffff, 16'hffff, "R7");
    do_op(1, 0, 2'd3, 1, 0, 2'd0, 0, 16'h0000, 16'h0000, "R7");
    // R8 status only
    do_op(1, 1, 2'd0, 0, 1, 2'd0, 1, 16'h8000, 16'h8000, "R8");
    do_op(1, 1, 2'd0, 1, 1, 2'd0, 0, 16'h0001, 16'h0001, "R8");
    // R9 destination isolation
    do_op(1, 1, 2'd0, 1, 0, 2'd0, 1, 16'h8000, 16'h8000, "R9");
    do_op(1, 1, 2'd3, 0, 0, 2'd0, 0, 16'h0000, 16'h0000, "R9");
    // R10 idle
    do_op(0, 1, 2'd3, 1, 0, 2'd0, 0, 16'h0000, 16'h0000, "R10");

    for (int i = 0; i < 300; i++) begin
      logic [31:0] r;
      r = $urandom;
      do_op(r[0] | r[1], r[2] | r[3] | r[4], r[6:5], r[7], (r[11:8] == 4'h0),
            r[13:12], r[14], 16'($urandom), 16'($urandom), "R5");
    end

    repeat (3) @(negedge clk_i);
    done = 1;
    summary();
  end
endmodule